// File: doc/BRIEF.md
# PCIe Bridge Local Interrupt Controller

This block gathers the event lines of a PCIe root-port bridge into one level interrupt. It has 32 event inputs, one for each bit of a sticky status register. Bits 0–7 are DMA-transfer-done lines and bits 8–15 are DMA-error lines. Bits 16–23 are the AXI-side post, fetch and discard errors and the AXI doorbell, followed by the same four for the PCIe side. Bits 24–27 are legacy INTx lines A to D. Bits 28–31 are MSI, AER, power-management/LTR/hotplug and system error. A 32-bit enable register selects which latched bits may drive the interrupt output. The interrupt stays high for as long as any enabled status bit remains set.

Software uses a small word-wide register port with a single-cycle write strobe and a read strobe. Each read returns registered data one cycle later. The status register is write-one-to-clear and the enable register is read-write. A third, read-only word presents events by logical number rather than by bit. Event numbers 0–23 match their bit positions. Event 24 folds the four enabled INTx bits into one. Events 25–28 each sit three bits below their status bits. A driver acknowledges the INTx event by clearing all four INTx bits together. It masks or unmasks the INTx event by clearing or setting all four enable bits together.

Top module: `pcie_bridge_irq_ctrl`

## Requirements
- R1: After reset the status register, the enable register, the read data and the interrupt output are all zero.
- R2: When event input bit i is high at a clock edge, status bit i is set from the next cycle. A one-cycle pulse or a held level both set it. The bit stays set until software clears it.
- R3: A write to offset 0x0 clears each status bit whose data bit is 1 and leaves bits written with 0 unchanged. Writing 0x0F00_0000 acknowledges the whole INTx group.
- R4: If an event input and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R5: A write to offset 0x4 loads the enable register. Reads at offset 0x4 return it, and reads at offset 0x0 return the status register.
- R6: The interrupt output is high exactly while (status AND enable) is non-zero. It follows a status or enable change in the same cycle the register changes.
- R7: Offset 0x8 reads the event word. Bits 0–23 are status AND enable at the same index. Bit 24 is the OR of enabled bits 24–27. Bits 25–28 are the enabled status bits 28–31. Bits 29–31 read as zero.
- R8: Writes to offset 0x8 or to any unmapped offset change nothing. Reads of an unmapped offset return zero.
- R9: Read data appears on the cycle after the read strobe and holds its value until the next read strobe.
- R10: A write to the status offset leaves the enable register unchanged, and a write to the enable offset clears no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | 32 | Event inputs, one for each status bit |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 4 | Byte offset of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt output |

## Verification
Events and writes take effect at the clock edge on which they are sampled, and the interrupt output reflects them immediately after that edge. Read data is due one edge after the read strobe. The driver changes inputs on the falling edge and returns them to idle on the next falling edge. The scoreboard monitor sees a read strobe at the rising edge and compares the popped expected word at the following falling edge. The level of the interrupt line, and the hold of the read data while no read is issued, are checked directly at falling edges once the driving edge has passed.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int REG_W   = 32;
    localparam int DMA_CH  = 8;
    localparam int XERR_N  = 8;
    localparam int INTX_N  = 4;
    localparam int TAIL_N  = 4;
    localparam int INTX_LSB = 2 * DMA_CH + XERR_N;
    localparam int INTX_EVT = INTX_LSB;
    localparam int SHIFT    = INTX_N - 1;
    localparam int EVT_N    = INTX_EVT + 1 + TAIL_N;

    localparam logic [3:0] OFF_STATUS = 4'h0;
    localparam logic [3:0] OFF_ENABLE = 4'h4;
    localparam logic [3:0] OFF_EVENT  = 4'h8;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_EVENT  = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    function automatic reg_sel_e decode_off(input logic [3:0] a);
        reg_sel_e s;
        unique case (a)
            OFF_STATUS: s = SEL_STATUS;
            OFF_ENABLE: s = SEL_ENABLE;
            OFF_EVENT:  s = SEL_EVENT;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/irqc_status_bank.sv
module irqc_status_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] status_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                status_o[i] <= 1'b0;
            else if (set_i[i])
                status_o[i] <= 1'b1;
            else if (clr_i[i])
                status_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/irqc_event_fold.sv
module irqc_event_fold
    import irqc_pkg::*;
(
    input  logic [REG_W-1:0] enabled_i,
    output logic [EVT_N-1:0] evt_o
);
    for (genvar e = 0; e < EVT_N; e++) begin : g_evt
        if (e < INTX_EVT) begin : g_direct
            assign evt_o[e] = enabled_i[e];
        end else if (e == INTX_EVT) begin : g_intx
            assign evt_o[e] = |enabled_i[INTX_LSB +: INTX_N];
        end else begin : g_shift
            assign evt_o[e] = enabled_i[e + SHIFT];
        end
    end
endmodule

// File: rtl/irqc_reg_port.sv
module irqc_reg_port
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [3:0]       addr,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] status_i,
    input  logic [REG_W-1:0] enable_i,
    input  logic [EVT_N-1:0] evt_i,
    output logic [REG_W-1:0] clr_o,
    output logic             en_we_o,
    output logic [REG_W-1:0] rdata
);
    reg_sel_e sel;
    logic [REG_W-1:0] rd_mux;

    assign sel     = decode_off(addr);
    assign clr_o   = (wr_en && sel == SEL_STATUS) ? wdata : '0;
    assign en_we_o = wr_en && sel == SEL_ENABLE;

    always_comb begin
        unique case (sel)
            SEL_STATUS: rd_mux = status_i;
            SEL_ENABLE: rd_mux = enable_i;
            SEL_EVENT:  rd_mux = {{(REG_W - EVT_N){1'b0}}, evt_i};
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_mux;
    end
endmodule

// File: rtl/pcie_bridge_irq_ctrl.sv
module pcie_bridge_irq_ctrl
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] evt_in,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [3:0]       addr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic             irq
);
    logic [REG_W-1:0] status_q;
    logic [REG_W-1:0] mask_q;
    logic [REG_W-1:0] clr_vec;
    logic             en_we;
    logic [EVT_N-1:0] evt_vec;
    logic [REG_W-1:0] enabled;

    irqc_status_bank #(.W(REG_W)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (evt_in),
        .clr_i    (clr_vec),
        .status_o (status_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (en_we)
            mask_q <= wdata;
    end

    assign enabled = status_q & mask_q;
    assign irq     = |enabled;

    irqc_event_fold u_fold (
        .enabled_i (enabled),
        .evt_o     (evt_vec)
    );

    irqc_reg_port u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .status_i (status_q),
        .enable_i (mask_q),
        .evt_i    (evt_vec),
        .clr_o    (clr_vec),
        .en_we_o  (en_we),
        .rdata    (rdata)
    );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] evt_in,
    input logic        wr_en,
    input logic        rd_en,
    input logic [3:0]  addr,
    input logic [31:0] wdata,
    input logic [31:0] rdata,
    input logic        irq,
    input logic [31:0] status_q,
    input logic [31:0] mask_q
);
    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_in != '0) |=> ((status_q & $past(evt_in)) == $past(evt_in)));

    a_r2_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == 4'h0) |=> ((status_q & $past(status_q)) == $past(status_q)));

    a_r3_clear_applies: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 4'h0) |=> ((status_q & $past(wdata) & ~$past(evt_in)) == '0));

    a_r5_enable_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 4'h4) |=> (mask_q == $past(wdata)));

    a_r10_enable_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == 4'h4) |=> $stable(mask_q));

    a_r6_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);

    a_r6_quiet_when_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q == '0) |-> !irq);

    a_r9_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

bind pcie_bridge_irq_ctrl irqc_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_in   (evt_in),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .irq      (irq),
    .status_q (status_q),
    .mask_q   (mask_q)
);

// File: tb/pcie_bridge_irq_ctrl_tb.sv
`timescale 1ns/1ps
module pcie_bridge_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt_in = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [31:0] m_status = '0;
    logic [31:0] m_mask = '0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    pcie_bridge_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ev_word(input logic [31:0] s, input logic [31:0] m);
        logic [31:0] e = s & m;
        logic [31:0] v = '0;
        v[23:0]  = e[23:0];
        v[24]    = |e[27:24];
        v[28:25] = e[31:28];
        return v;
    endfunction

    function automatic logic [31:0] model_read(input logic [3:0] a);
        case (a)
            4'h0: return m_status;
            4'h4: return m_mask;
            4'h8: return ev_word(m_status, m_mask);
            default: return '0;
        endcase
    endfunction

    task automatic step(input logic [31:0] ev, input logic w, input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        evt_in = ev; wr_en = w; addr = a; wdata = d;
        @(negedge clk);
        evt_in = '0; wr_en = 1'b0; wdata = '0;
        if (w && a == 4'h0) m_status = m_status & ~d;
        if (w && a == 4'h4) m_mask = d;
        m_status = m_status | ev;
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        @(negedge clk);
        exp_q.push_back(model_read(a));
        tag_q.push_back(tag);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    always @(posedge clk) begin
        if (rd_en && rst_n) begin
            @(negedge clk);
            if (exp_q.size() == 0) begin
                check("R9 unexpected read data", rdata, 32'hx);
            end else begin
                check(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 irq after reset", {31'b0, irq}, 32'h0);
        check("R1 rdata after reset", rdata, 32'h0);
        rst_n = 1'b1;
        rd(4'h0, "R1 status reset");
        rd(4'h4, "R1 enable reset");
        rd(4'h8, "R1 event word reset");

        // R2 pulse sets and sticks
        step(32'h0000_0081, 1'b0, 4'h0, '0);
        rd(4'h0, "R2 status after pulse");
        check("R6 irq low with enable zero", {31'b0, irq}, 32'h0);
        repeat (3) @(negedge clk);
        rd(4'h0, "R2 status sticky");

        // R5 and R6
        step('0, 1'b1, 4'h4, 32'h0000_0001);
        check("R6 irq high on enabled bit", {31'b0, irq}, 32'h1);
        rd(4'h4, "R5 enable readback");
        rd(4'h0, "R10 enable write keeps status");

        // R3 clear
        step('0, 1'b1, 4'h0, 32'h0000_0001);
        check("R6 irq low after clear", {31'b0, irq}, 32'h0);
        rd(4'h0, "R3 w1c clears only ones");
        rd(4'h4, "R10 status write keeps enable");

        // R4 set wins
        step(32'h0000_0040, 1'b0, 4'h0, '0);
        step(32'h0000_0020, 1'b1, 4'h0, 32'h0000_0060);
        rd(4'h0, "R4 set wins over clear");
        check("R4 model value", m_status, 32'h0000_00A0);

        // R7 event word folding
        step(32'h2402_0000, 1'b1, 4'h4, 32'hFFFF_FFFF);
        rd(4'h8, "R7 event word all enabled");
        check("R7 hand value", ev_word(m_status, m_mask), 32'h0502_00A0);
        check("R6 irq high", {31'b0, irq}, 32'h1);
        step('0, 1'b1, 4'h4, 32'hF0FF_FFFF);
        rd(4'h8, "R7 intx disabled");
        step(32'h0900_0000, 1'b1, 4'h4, 32'h0800_0000);
        rd(4'h8, "R7 single intx line");
        check("R6 irq from intx D", {31'b0, irq}, 32'h1);
        step('0, 1'b1, 4'h0, 32'h0F00_0000);
        rd(4'h0, "R3 intx group ack");
        check("R6 irq low after intx ack", {31'b0, irq}, 32'h0);

        // R8 ignored writes
        step('0, 1'b1, 4'h4, 32'hFFFF_FFFF);
        step('0, 1'b1, 4'h8, 32'hFFFF_FFFF);
        step('0, 1'b1, 4'hC, 32'h0000_0000);
        step('0, 1'b1, 4'h1, 32'hFFFF_FFFF);
        rd(4'h0, "R8 status after ignored writes");
        rd(4'h4, "R8 enable after ignored writes");
        rd(4'hC, "R8 unmapped read zero");
        rd(4'h1, "R8 unaligned read zero");

        // R4 with a held level input
        step(32'h4000_0000, 1'b0, 4'h0, '0);
        step(32'h4000_0000, 1'b1, 4'h0, 32'h4000_0000);
        rd(4'h8, "R4 level held through clear");
        step('0, 1'b1, 4'h0, 32'hFFFF_FFFF);
        rd(4'h0, "R3 clear all");
        check("R6 irq low at end", {31'b0, irq}, 32'h0);

        // R9 hold
        rd(4'h4, "R9 read enable");
        repeat (3) @(negedge clk);
        check("R9 rdata held", rdata, 32'hFFFF_FFFF);

        repeat (3) @(negedge clk);
        check("R9 scoreboard drained", exp_q.size(), 32'd0);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule